// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Sequencer

This block sequences a 6-bit successive-approximation conversion without a fixed bit clock. A one-cycle start pulse opens a short sampling window. The block then sets one trial bit at a time, starting from the most significant, and waits for the comparator to report a decision. A completion detector declares a decision as soon as either comparator output goes high. After each decision the block holds the comparator in reset until both outputs fall, updates the trial word, and releases the comparator for the next bit.

Once the data bits are decided, the block publishes the code with a one-cycle done pulse. It then runs a seventh comparison with the comparator inputs shorted together. The polarity of that decision steps a saturating trim counter up or down, and over many conversions the counter averages the comparator offset. A programmable limit, counted in reference-clock cycles from acceptance of the start pulse to the last data decision, marks a conversion as overrun. An overrun conversion skips the offset comparison but still delivers its data.

Top module: `sar_seq`

## Requirements
- R1: In reset and right after it, result is 0, done is 0, offsetTrim is 128, compReset is 1, samplePhase is 0, compShort is 0 and dacTrial is 0.
- R2: A start pulse accepted in idle opens a sampling window of SAMPLE_CYCLES cycles, beginning the cycle after the pulse. During the window samplePhase is 1, compReset is 1 and dacTrial is 0. In the next cycle dacTrial is 100000 (binary) and compReset is 0.
- R3: The code is decided MSB first. Each trial word is the bits decided so far plus a 1 at the bit under test. A bit is kept at 1 when compP is high at its decision.
- R4: A decision happens only when compP or compN is high. While both are low during a comparison, dacTrial does not change.
- R5: After every decision, compReset goes high and stays high until both comparator outputs are low. A conversion with its offset comparison shows exactly 7 rising edges of compReset. An overrun conversion shows exactly 6.
- R6: After the sixth decision, done is high for exactly one cycle, and result holds the decided code.
- R7: When no overrun occurs, a comparison with compShort high follows the data bits. If compP is high at its decision, offsetTrim rises by 1; otherwise it falls by 1.
- R8: When the elapsed cycle count reaches timeoutLimit before the sixth decision, no comparison with compShort high takes place and offsetTrim is unchanged. The result is still delivered.
- R9: offsetTrim saturates at 255 and at 0 and never wraps.
- R10: A start pulse that arrives while a conversion or its offset comparison is in progress is ignored. It produces no extra sampling window and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleStrobe | input | 1 | One-cycle start pulse |
| compP | input | 1 | Comparator positive output, high means input above trial |
| compN | input | 1 | Comparator negative output |
| timeoutLimit | input | TIMER_W | Overrun limit in reference-clock cycles |
| dacTrial | output | NBITS | DAC switch control word |
| samplePhase | output | 1 | Sampling window: top plates to common mode, bottom plates track |
| compReset | output | 1 | Comparator reset |
| compShort | output | 1 | Comparator input short for the offset comparison |
| result | output | NBITS | Converted code |
| done | output | 1 | One-cycle pulse marking a new result |
| offsetTrim | output | TRIM_W | Averaged offset trim value |

## Verification
A behavioural comparator in the bench answers every trial against a chosen input level after a programmable number of cycles. Input levels at zero, full scale, alternating bit patterns and mid values show whether the bit order and the keep-or-drop rule are right, because each level produces a distinct trial sequence. Response delays that fall on either side of the overrun limit show whether the offset comparison is taken or skipped. Long runs of one offset polarity drive the trim counter into both rails. A second start pulse sent during a slow conversion shows whether the block ignores requests while it is busy.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_COMPARE,
    ST_RECOVER,
    ST_OFFSET
  } seqState_t;

  typedef struct packed {
    logic clearCode;
    logic trialEn;
    logic decide;
    logic finish;
    logic offsetSample;
  } seqStrobes_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NBITS         = 6,
  parameter int SAMPLE_CYCLES = 2,
  parameter int TIMER_W       = 16,
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int SCW  = $clog2(SAMPLE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleStrobe,
  input  logic               ready,
  input  logic [TIMER_W-1:0] timeoutLimit,
  output logic [IDXW-1:0]    bitIdx,
  output seqStrobes_t        strobes,
  output logic               samplePhase,
  output logic               compReset,
  output logic               compShort
);

  seqState_t          state, nextState;
  logic [SCW-1:0]     sampleCnt;
  logic [TIMER_W-1:0] elapsed;
  logic               bitsDone;
  logic               overrunNow;
  logic               accept;

  assign accept     = (state == ST_IDLE) && sampleStrobe;
  assign overrunNow = (elapsed >= timeoutLimit);

  always_comb begin
    nextState   = state;
    strobes     = '0;
    samplePhase = 1'b0;
    compReset   = 1'b1;
    compShort   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (sampleStrobe) begin
          nextState         = ST_SAMPLE;
          strobes.clearCode = 1'b1;
        end
      end
      ST_SAMPLE: begin
        samplePhase = 1'b1;
        if (sampleCnt == SCW'(SAMPLE_CYCLES - 1)) nextState = ST_COMPARE;
      end
      ST_COMPARE: begin
        compReset       = 1'b0;
        strobes.trialEn = 1'b1;
        if (ready) begin
          strobes.decide = 1'b1;
          nextState      = ST_RECOVER;
          if (bitIdx == '0) begin
            strobes.finish = 1'b1;
            if (overrunNow) nextState = ST_IDLE;
          end
        end
      end
      ST_RECOVER: begin
        if (!ready) nextState = bitsDone ? ST_OFFSET : ST_COMPARE;
      end
      ST_OFFSET: begin
        compReset = 1'b0;
        compShort = 1'b1;
        if (ready) begin
          strobes.offsetSample = 1'b1;
          nextState            = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sampleCnt <= '0;
      bitIdx    <= '0;
      elapsed   <= '0;
      bitsDone  <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        sampleCnt <= '0;
        bitIdx    <= IDXW'(NBITS - 1);
        elapsed   <= '0;
        bitsDone  <= 1'b0;
      end else begin
        if (state == ST_SAMPLE) sampleCnt <= sampleCnt + 1'b1;
        if (strobes.decide && (bitIdx != '0)) bitIdx <= bitIdx - 1'b1;
        if (strobes.finish) bitsDone <= 1'b1;
        if ((state != ST_IDLE) && !bitsDone && (elapsed != '1))
          elapsed <= elapsed + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_data.sv
module sar_data
  import sar_seq_pkg::*;
#(
  parameter int NBITS  = 6,
  parameter int TRIM_W = 8,
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W - 1),
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [IDXW-1:0]   bitIdx,
  input  logic              compP,
  output logic [NBITS-1:0]  dacTrial,
  output logic [NBITS-1:0]  result,
  output logic              done,
  output logic [TRIM_W-1:0] offsetTrim
);

  logic [NBITS-1:0] code;
  logic [NBITS-1:0] trialMask;
  logic [NBITS-1:0] nextCode;

  genvar gi;
  generate
    for (gi = 0; gi < NBITS; gi++) begin : g_mask
      assign trialMask[gi] = (bitIdx == IDXW'(gi));
      assign nextCode[gi]  = trialMask[gi] ? compP : code[gi];
    end
  endgenerate

  assign dacTrial = strobes.trialEn ? (code | trialMask) : code;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.clearCode)   code   <= '0;
      else if (strobes.decide) code   <= nextCode;
      if (strobes.finish)      result <= nextCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetTrim <= TRIM_MID;
    end else if (strobes.offsetSample) begin
      if (compP) begin
        if (offsetTrim != TRIM_MAX) offsetTrim <= offsetTrim + 1'b1;
      end else begin
        if (offsetTrim != '0) offsetTrim <= offsetTrim - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int NBITS         = 6,
  parameter int SAMPLE_CYCLES = 2,
  parameter int TIMER_W       = 16,
  parameter int TRIM_W        = 8,
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleStrobe,
  input  logic               compP,
  input  logic               compN,
  input  logic [TIMER_W-1:0] timeoutLimit,
  output logic [NBITS-1:0]   dacTrial,
  output logic               samplePhase,
  output logic               compReset,
  output logic               compShort,
  output logic [NBITS-1:0]   result,
  output logic               done,
  output logic [TRIM_W-1:0]  offsetTrim
);

  logic        ready;
  logic [IDXW-1:0] bitIdx;
  seqStrobes_t strobes;

  assign ready = compP | compN;

  sar_ctrl #(
    .NBITS(NBITS), .SAMPLE_CYCLES(SAMPLE_CYCLES), .TIMER_W(TIMER_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .ready(ready),
    .timeoutLimit(timeoutLimit), .bitIdx(bitIdx), .strobes(strobes),
    .samplePhase(samplePhase), .compReset(compReset), .compShort(compShort)
  );

  sar_data #(
    .NBITS(NBITS), .TRIM_W(TRIM_W)
  ) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIdx(bitIdx),
    .compP(compP), .dacTrial(dacTrial), .result(result), .done(done),
    .offsetTrim(offsetTrim)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS  = 6,
  parameter int TRIM_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              compP,
  input logic              compN,
  input logic [NBITS-1:0]  dacTrial,
  input logic              samplePhase,
  input logic              compReset,
  input logic              compShort,
  input logic              done,
  input logic [TRIM_W-1:0] offsetTrim
);

  // R2
  sample_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    samplePhase |-> (compReset && !compShort && (dacTrial == '0)));

  // R4
  hold_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!compReset && !compShort && !compP && !compN) |=> $stable(dacTrial));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  trim_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offsetTrim != $past(offsetTrim)) |->
      ((offsetTrim == $past(offsetTrim) + 1'b1) ||
       (offsetTrim == $past(offsetTrim) - 1'b1)));

  // R9
  trim_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(offsetTrim) == '1) |-> (offsetTrim != '0));

  // R9
  trim_no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(offsetTrim) == '0) |-> (offsetTrim != '1));

  // R8
  short_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    compShort |-> (!samplePhase && !compReset));

endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS), .TRIM_W(TRIM_W)) chkInst (
  .clk(clk), .rstN(rstN), .compP(compP), .compN(compN), .dacTrial(dacTrial),
  .samplePhase(samplePhase), .compReset(compReset), .compShort(compShort),
  .done(done), .offsetTrim(offsetTrim)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic        compP = 1'b0;
  logic        compN = 1'b0;
  logic [15:0] timeoutLimit = 16'd60;
  logic [5:0]  dacTrial;
  logic        samplePhase, compReset, compShort;
  logic [5:0]  result;
  logic        done;
  logic [7:0]  offsetTrim;

  always #10 clk = ~clk;

  sar_seq dut (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .compP(compP),
    .compN(compN), .timeoutLimit(timeoutLimit), .dacTrial(dacTrial),
    .samplePhase(samplePhase), .compReset(compReset), .compShort(compShort),
    .result(result), .done(done), .offsetTrim(offsetTrim)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural comparator
  int  modelVin = 0;
  bit  modelOffPos = 1'b0;
  int  modelDelay = 0;
  int  waitCnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (compReset) begin
        compP = 1'b0; compN = 1'b0; waitCnt = 0;
      end else if (!compP && !compN) begin
        if (waitCnt >= modelDelay) begin
          compP = compShort ? modelOffPos : (modelVin >= int'(dacTrial));
          compN = !compP;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  // scoreboard monitor
  logic [5:0]  expQ[$];
  int          doneCount = 0;
  int          resetRises = 0;
  bit          shortSeen = 1'b0;
  logic [35:0] trialLog = '0;
  bit          prevReset = 1'b1;
  bit          prevDone = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (done) begin
          if (prevDone) chk(1'b0, "R6", "done longer than one cycle", 1, 0);
          if (expQ.size() == 0) begin
            chk(1'b0, "R10", "unexpected done", 1, 0);
          end else begin
            logic [5:0] e;
            e = expQ.pop_front();
            chk(result == e, "R3", "result code", int'(result), int'(e));
          end
          doneCount++;
        end
        if (compReset && !prevReset) resetRises++;
        if (!compReset && prevReset && !compShort)
          trialLog = {trialLog[29:0], dacTrial};
        if (compShort) shortSeen = 1'b1;
      end
      prevReset = compReset;
      prevDone  = done;
    end
  end

  int expTrim = 128;

  task automatic convert(input int vin, input bit offPos, input int dly,
                         input bit expOverrun, input bit probe);
    logic [35:0] expTrials;
    logic [5:0]  code;
    int          startDone;
    expTrials = '0;
    code = '0;
    for (int b = 5; b >= 0; b--) begin
      logic [5:0] t;
      t = code | (6'd1 << b);
      expTrials = {expTrials[29:0], t};
      if (vin >= int'(t)) code = t;
    end
    modelVin = vin; modelOffPos = offPos; modelDelay = dly;
    startDone = doneCount;
    resetRises = 0; shortSeen = 1'b0; trialLog = '0;
    expQ.push_back(code);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    if (probe) begin
      chk(samplePhase && compReset && dacTrial == 0, "R2", "sample window 1",
          int'(samplePhase), 1);
      @(negedge clk);
      chk(samplePhase && compReset && dacTrial == 0, "R2", "sample window 2",
          int'(samplePhase), 1);
      @(negedge clk);
      chk(!samplePhase && !compReset && dacTrial == 6'b100000, "R2",
          "first trial", int'(dacTrial), 32);
      if (dly >= 12) begin
        repeat (2) @(negedge clk);
        sampleStrobe = 1'b1;
        @(negedge clk);
        sampleStrobe = 1'b0;
        repeat (6) @(negedge clk);
        chk(dacTrial == 6'b100000, "R4", "trial held without ready",
            int'(dacTrial), 32);
        chk(!samplePhase, "R10", "no new sample window", int'(samplePhase), 0);
      end
    end
    while (doneCount == startDone) @(negedge clk);
    repeat (2 * dly + 12) @(negedge clk);
    if (!expOverrun) begin
      if (offPos && expTrim < 255) expTrim++;
      else if (!offPos && expTrim > 0) expTrim--;
    end
    if (probe) begin
      chk(trialLog == expTrials, "R3", "trial sequence low bits",
          int'(trialLog[31:0]), int'(expTrials[31:0]));
      chk(resetRises == (expOverrun ? 6 : 7), "R5", "reset rises",
          resetRises, expOverrun ? 6 : 7);
      chk(shortSeen == !expOverrun, expOverrun ? "R8" : "R7",
          "short cycle taken", int'(shortSeen), int'(!expOverrun));
      chk(doneCount == startDone + 1, "R10", "done count",
          doneCount - startDone, 1);
    end
    chk(int'(offsetTrim) == expTrim, expOverrun ? "R8" : "R7", "trim value",
        int'(offsetTrim), expTrim);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(result == 0 && done == 0, "R1", "reset result/done", int'(result), 0);
    chk(offsetTrim == 8'd128, "R1", "reset trim", int'(offsetTrim), 128);
    chk(compReset && !samplePhase && !compShort && dacTrial == 0, "R1",
        "reset controls", int'(dacTrial), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(offsetTrim == 8'd128 && !done, "R1", "after reset trim",
        int'(offsetTrim), 128);

    timeoutLimit = 16'd60;
    convert(0,  1'b1, 1, 1'b0, 1'b1);
    convert(63, 1'b1, 0, 1'b0, 1'b1);
    convert(42, 1'b0, 3, 1'b0, 1'b1);
    convert(21, 1'b1, 1, 1'b0, 1'b1);
    convert(37, 1'b1, 15, 1'b1, 1'b1);   // R8 overrun, R10 extra strobe
    convert(32, 1'b0, 15, 1'b1, 1'b1);   // R8 overrun
    timeoutLimit = 16'd1000;
    convert(31, 1'b1, 15, 1'b0, 1'b1);   // slow but within limit
    timeoutLimit = 16'd0;
    convert(9,  1'b1, 0, 1'b1, 1'b1);    // R8 zero limit
    timeoutLimit = 16'd1000;

    for (int i = 0; i < 130; i++) convert((i * 7) % 64, 1'b1, 0, 1'b0, 1'b0);
    chk(offsetTrim == 8'd255, "R9", "trim top rail", int'(offsetTrim), 255);
    convert(5, 1'b1, 0, 1'b0, 1'b1);
    chk(offsetTrim == 8'd255, "R9", "trim held at top", int'(offsetTrim), 255);
    for (int i = 0; i < 260; i++) convert((i * 11) % 64, 1'b0, 0, 1'b0, 1'b0);
    chk(offsetTrim == 8'd0, "R9", "trim bottom rail", int'(offsetTrim), 0);
    convert(50, 1'b0, 0, 1'b0, 1'b1);
    chk(offsetTrim == 8'd0, "R9", "trim held at bottom", int'(offsetTrim), 0);

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R6", "pending results", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule